// File: doc/BRIEF.md
# Rotating Multi-Line Stereo Window Buffer

This block takes two raster pixel streams, one from each camera of a stereo pair, and keeps the most recent rows of both images on chip. A matching stage placed after it can then read a vertical stack of lines together with a short run of horizontal neighbours for each line. Pixels are 8-bit grayscale and arrive one per clock. Two runtime inputs set the geometry: the row width in pixels, and how many lines the window is tall.

For each image the block keeps one more line memory than the window height. During each row one memory takes the incoming pixels. All the others are read at the same column address the writer uses, so the previous rows come out aligned with the pixel now arriving. The role of writer moves to the next memory in a ring each time a row ends. Each line that is read feeds a byte-wide shift chain. The chain holds the newest few columns of that line, which is enough taps for every disparity step the matcher looks at. The lines are presented oldest first. A valid flag marks the cycles in which every tap in every slot belongs to the current row of a fully stored window.

Top module: `stereo_window_buffer`

## Requirements
- R1: The effective line count n is `n_lines` clamped to the range 1..MAX_LINES. A value of 0 acts as 1, and any value above MAX_LINES acts as MAX_LINES.
- R2: The effective row width X is `x_res` clamped to 1..MAX_COLS. The column of each input pixel counts 0..X-1 and then wraps to 0. `win_col` reports the column of the newest tap, so it steps by one and wraps after X-1.
- R3: At any time exactly one line memory per image holds the write role, and that memory is one of the first n+1.
- R4: The write role moves to the next memory in the ring of n+1 (wrapping from index n back to 0) only when a row wraps, and at no other time.
- R5: Number input rows from 0 after reset, and let r be the row of the pixel shown in byte 0. Then window slot k (0 ≤ k < n) holds image row r−n+k. Slot 0 is the oldest line and slot n−1 is the newest stored line. Slot k occupies bits [(k·TAPS+TAPS)·8−1 : k·TAPS·8].
- R6: Inside a slot, byte j (bits [j·8+7 : j·8]) holds column c−j, where c is `win_col`. Byte 0 is the newest column.
- R7: A pixel presented at column c shows up in the window output after two rising clock edges.
- R8: Window slots with index k ≥ n always read as zero.
- R9: `win_valid` is high exactly when at least n complete rows were stored before row r and c ≥ TAPS−1.
- R10: While reset is high and right after it, both windows are all zero, `win_col` is 0 and `win_valid` is low.
- R11: The left and right images are buffered through identical but separate storage, so each window shows only its own image's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| left_px | input | 8 | Left image pixel, one per clock |
| right_px | input | 8 | Right image pixel, one per clock |
| x_res | input | 11 | Row width in pixels (clamped to 1..MAX_COLS) |
| n_lines | input | 5 | Window line count (clamped to 1..MAX_LINES) |
| left_win | output | MAX_LINES·TAPS·8 | Left window: slots oldest first, each slot's taps newest first |
| right_win | output | MAX_LINES·TAPS·8 | Right window, same layout as left |
| win_col | output | 11 | Column of the newest tap |
| win_valid | output | 1 | All taps of all active slots are current-row, fully stored data |

## Verification
Most internal faults become visible at the ports within one row. A write pointer that rotates at the wrong time, or goes past the n+1 ring, either puts a line in the wrong slot or overwrites a stored line. The window then shows a pixel from the wrong row at the next column where valid is high. An error in the slot index arithmetic or in the read-latency alignment shows up as a shifted row or column on the first valid cycle. An error in the line counter or the column comparison moves the rising edge of `win_valid` by one row or one column. The bench therefore compares every byte of every slot on every cycle against arithmetic pixel patterns, across several clamped geometries.

// File: rtl/swb_pkg.sv
package swb_pkg;

    localparam int PIX_W  = 8;
    localparam int XRES_W = 11;
    localparam int NSEL_W = 5;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [XRES_W-1:0] col_t;

    // Address-side pipeline stage that travels with the synchronous read.
    typedef struct packed {
        col_t col;
        logic full;
    } stage_t;

    function automatic int clamp_range(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/swb_ring_ctrl.sv
module swb_ring_ctrl
    import swb_pkg::*;
#(
    parameter int MAX_LINES = 4,
    parameter int MAX_COLS  = 64,
    localparam int MEMS  = MAX_LINES + 1,
    localparam int IDX_W = $clog2(MEMS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XRES_W-1:0] x_res,
    input  logic [NSEL_W-1:0] n_lines,
    output col_t              col,
    output logic [MEMS-1:0]   wr_oh,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  n_eff,
    output logic              full
);

    col_t             last_col;
    logic [IDX_W-1:0] lines_held;

    always_comb begin
        n_eff    = IDX_W'(clamp_range(int'(n_lines), 1, MAX_LINES));
        last_col = XRES_W'(clamp_range(int'(x_res), 1, MAX_COLS) - 1);
        full     = (lines_held >= n_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col        <= '0;
            wr_oh      <= MEMS'(1);
            wr_idx     <= '0;
            lines_held <= '0;
        end else if (col >= last_col) begin
            col <= '0;
            if (wr_idx >= n_eff) begin
                wr_idx <= '0;
                wr_oh  <= MEMS'(1);
            end else begin
                wr_idx <= wr_idx + 1'b1;
                wr_oh  <= wr_oh << 1;
            end
            if (lines_held < n_eff)
                lines_held <= lines_held + 1'b1;
        end else begin
            col <= col + 1'b1;
        end
    end

endmodule

// File: rtl/swb_line_store.sv
module swb_line_store
    import swb_pkg::*;
#(
    parameter int MEMS     = 5,
    parameter int MAX_COLS = 64,
    localparam int AW = $clog2(MAX_COLS)
) (
    input  logic                 clk,
    input  logic [MEMS-1:0]      wr_oh,
    input  logic [AW-1:0]        addr,
    input  pix_t                 wr_px,
    output logic [MEMS-1:0][PIX_W-1:0] rd_px
);

    for (genvar m = 0; m < MEMS; m++) begin : g_line
        pix_t line_mem [MAX_COLS];

        always_ff @(posedge clk) begin
            if (wr_oh[m])
                line_mem[addr] <= wr_px;
            rd_px[m] <= line_mem[addr];
        end
    end

endmodule

// File: rtl/swb_tap_shift.sv
module swb_tap_shift
    import swb_pkg::*;
#(
    parameter int MAX_LINES = 4,
    parameter int TAPS      = 4,
    localparam int MEMS  = MAX_LINES + 1,
    localparam int IDX_W = $clog2(MEMS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [MEMS-1:0][PIX_W-1:0]   rd_px,
    input  logic [IDX_W-1:0]             wr_q,
    input  logic [IDX_W-1:0]             n_eff,
    output logic [MAX_LINES-1:0][TAPS-1:0][PIX_W-1:0] win
);

    pix_t pick [MAX_LINES];

    // Slot k takes the memory k+1 places after the writer in the ring of n+1.
    always_comb begin
        for (int k = 0; k < MAX_LINES; k++) begin
            int idx;
            idx = int'(wr_q) + 1 + k;
            if (idx > int'(n_eff))
                idx = idx - (int'(n_eff) + 1);
            if (k < int'(n_eff))
                pick[k] = rd_px[IDX_W'(idx)];
            else
                pick[k] = '0;
        end
    end

    for (genvar k = 0; k < MAX_LINES; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                win[k] <= '0;
            else
                win[k] <= {win[k][TAPS-2:0], pick[k]};
        end
    end

endmodule

// File: rtl/stereo_window_buffer.sv
module stereo_window_buffer
    import swb_pkg::*;
#(
    parameter int MAX_LINES = 4,
    parameter int MAX_COLS  = 64,
    parameter int TAPS      = 4,
    localparam int MEMS  = MAX_LINES + 1,
    localparam int IDX_W = $clog2(MEMS),
    localparam int AW    = $clog2(MAX_COLS),
    localparam int WIN_W = MAX_LINES * TAPS * PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        left_px,
    input  logic [7:0]        right_px,
    input  logic [10:0]       x_res,
    input  logic [4:0]        n_lines,
    output logic [WIN_W-1:0]  left_win,
    output logic [WIN_W-1:0]  right_win,
    output logic [10:0]       win_col,
    output logic              win_valid
);

    col_t             col;
    logic [MEMS-1:0]  wr_oh;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] n_eff;
    logic             full;

    swb_ring_ctrl #(.MAX_LINES(MAX_LINES), .MAX_COLS(MAX_COLS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .x_res   (x_res),
        .n_lines (n_lines),
        .col     (col),
        .wr_oh   (wr_oh),
        .wr_idx  (wr_idx),
        .n_eff   (n_eff),
        .full    (full)
    );

    logic [MEMS-1:0][PIX_W-1:0] rd_left, rd_right;

    swb_line_store #(.MEMS(MEMS), .MAX_COLS(MAX_COLS)) u_store_l (
        .clk   (clk),
        .wr_oh (wr_oh),
        .addr  (col[AW-1:0]),
        .wr_px (left_px),
        .rd_px (rd_left)
    );

    swb_line_store #(.MEMS(MEMS), .MAX_COLS(MAX_COLS)) u_store_r (
        .clk   (clk),
        .wr_oh (wr_oh),
        .addr  (col[AW-1:0]),
        .wr_px (right_px),
        .rd_px (rd_right)
    );

    // Stage aligned with the synchronous read data.
    stage_t           stg;
    logic [IDX_W-1:0] wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= '0;
            wr_q <= '0;
        end else begin
            stg.col  <= col;
            stg.full <= full;
            wr_q     <= wr_idx;
        end
    end

    logic [MAX_LINES-1:0][TAPS-1:0][PIX_W-1:0] win_l, win_r;

    swb_tap_shift #(.MAX_LINES(MAX_LINES), .TAPS(TAPS)) u_shift_l (
        .clk   (clk),
        .rst   (rst),
        .rd_px (rd_left),
        .wr_q  (wr_q),
        .n_eff (n_eff),
        .win   (win_l)
    );

    swb_tap_shift #(.MAX_LINES(MAX_LINES), .TAPS(TAPS)) u_shift_r (
        .clk   (clk),
        .rst   (rst),
        .rd_px (rd_right),
        .wr_q  (wr_q),
        .n_eff (n_eff),
        .win   (win_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_col   <= '0;
            win_valid <= 1'b0;
        end else begin
            win_col   <= stg.col;
            win_valid <= stg.full && (stg.col >= XRES_W'(TAPS - 1));
        end
    end

    assign left_win  = win_l;
    assign right_win = win_r;

endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
    parameter int MAX_LINES = 4,
    parameter int MAX_COLS  = 64,
    parameter int TAPS      = 4,
    localparam int MEMS  = MAX_LINES + 1,
    localparam int IDX_W = $clog2(MEMS),
    localparam int WIN_W = MAX_LINES * TAPS * 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIN_W-1:0] left_win,
    input logic [WIN_W-1:0] right_win,
    input logic [10:0]      win_col,
    input logic             win_valid,
    input logic [10:0]      x_res,
    input logic [MEMS-1:0]  wr_oh,
    input logic [IDX_W-1:0] wr_idx,
    input logic [IDX_W-1:0] n_eff,
    input logic [10:0]      col
);

    // R3: a single writer, and the binary pointer agrees with the one-hot vector
    p_single_writer_r3: assert property (@(posedge clk) disable iff (rst)
        ($countones(wr_oh) == 1) && wr_oh[wr_idx]);

    // R3: writer stays inside the ring of n+1 memories
    p_writer_in_ring_r3: assert property (@(posedge clk) disable iff (rst)
        wr_idx <= n_eff);

    // R4: mid-row the write role does not move
    p_hold_mid_row_r4: assert property (@(posedge clk) disable iff (rst)
        (col != '0) |-> $stable(wr_oh));

    // R2: reported column steps by one unless it wraps to zero
    p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
        (win_col != '0) |-> (win_col == $past(win_col) + 11'd1));

    // R2: reported column never reaches the row width
    p_col_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(win_col) < MAX_COLS) && ((x_res == '0) || (win_col < x_res)));

    // R9: valid only once enough taps of the row have passed
    p_valid_taps_r9: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (int'(win_col) >= TAPS - 1));

    // R8: slots beyond the active line count stay at zero
    for (genvar k = 0; k < MAX_LINES; k++) begin : g_idle
        p_idle_slot_zero_r8: assert property (@(posedge clk) disable iff (rst)
            (k >= int'(n_eff)) |->
                ((left_win[k*TAPS*8 +: TAPS*8] == '0) &&
                 (right_win[k*TAPS*8 +: TAPS*8] == '0)));
    end

endmodule

bind stereo_window_buffer swb_checker #(
    .MAX_LINES (MAX_LINES),
    .MAX_COLS  (MAX_COLS),
    .TAPS      (TAPS)
) u_swb_chk (
    .clk       (clk),
    .rst       (rst),
    .left_win  (left_win),
    .right_win (right_win),
    .win_col   (win_col),
    .win_valid (win_valid),
    .x_res     (x_res),
    .wr_oh     (wr_oh),
    .wr_idx    (wr_idx),
    .n_eff     (n_eff),
    .col       (col)
);

// File: tb/stereo_window_buffer_test.sv
module stereo_window_buffer_test;

    localparam int MAX_LINES = 4;
    localparam int MAX_COLS  = 64;
    localparam int TAPS      = 4;
    localparam int WIN_W     = MAX_LINES * TAPS * 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       left_px = '0, right_px = '0;
    logic [10:0]      x_res = 11'd8;
    logic [4:0]       n_lines = 5'd2;
    logic [WIN_W-1:0] left_win, right_win;
    logic [10:0]      win_col;
    logic             win_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    stereo_window_buffer #(.MAX_LINES(MAX_LINES), .MAX_COLS(MAX_COLS), .TAPS(TAPS)) uut (
        .clk       (clk),
        .rst       (rst),
        .left_px   (left_px),
        .right_px  (right_px),
        .x_res     (x_res),
        .n_lines   (n_lines),
        .left_win  (left_win),
        .right_win (right_win),
        .win_col   (win_col),
        .win_valid (win_valid)
    );

    function automatic logic [7:0] pxl(input int img, input int r, input int c);
        if (img == 0) return 8'((r * 53 + c * 7 + 91) & 255);
        return 8'((r * 29 + c * 13 + 5) & 255);
    endfunction

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic chk(input string req, input logic [WIN_W-1:0] act,
                       input logic [WIN_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare one window against the arithmetic pattern for row r, column c.
    task automatic check_win(input int img, input int r, input int c, input int n,
                             input bit full_chk);
        logic [WIN_W-1:0] act;
        act = (img == 0) ? left_win : right_win;
        for (int k = 0; k < MAX_LINES; k++) begin
            logic [TAPS*8-1:0] exp_slot;
            exp_slot = '0;
            if (k < n) begin
                if (!full_chk) continue;
                for (int j = 0; j < TAPS; j++)
                    exp_slot[j*8 +: 8] = pxl(img, r - n + k, c - j);
                // R5 slot order oldest first, R6 newest column in byte 0, R11 per image
                chk((img == 0) ? "R5 R6 R11 left slot" : "R5 R6 R11 right slot",
                    WIN_W'(act[k*TAPS*8 +: TAPS*8]), WIN_W'(exp_slot));
            end else begin
                // R8 idle slot zero
                chk("R8 idle slot", WIN_W'(act[k*TAPS*8 +: TAPS*8]), '0);
            end
        end
    endtask

    task automatic run_cfg(input int n_in, input int x_in, input int rows);
        int n, xw, total;
        n     = clampi(n_in, 1, MAX_LINES);   // R1 clamp
        xw    = clampi(x_in, 1, MAX_COLS);    // R2 clamp
        total = rows * xw;
        @(negedge clk);
        rst     = 1'b1;
        n_lines = 5'(n_in);
        x_res   = 11'(x_in);
        repeat (2) @(negedge clk);
        // R10 reset state
        chk("R10 left window", left_win, '0);
        chk("R10 right window", right_win, '0);
        chk("R10 column", WIN_W'(win_col), '0);
        chk("R10 valid", WIN_W'(win_valid), '0);
        for (int i = 0; i < total + 2; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 0) rst = 1'b0;
            if (i >= 2) begin
                int r, c;
                bit ev;
                r  = (i - 2) / xw;
                c  = (i - 2) % xw;
                ev = (r >= n) && (c >= TAPS - 1);
                // R7 two-edge latency, R2 column report
                chk("R2 R7 column", WIN_W'(win_col), WIN_W'(c));
                // R9 valid rule
                chk("R9 valid", WIN_W'(win_valid), WIN_W'(ev));
                check_win(0, r, c, n, ev);
                check_win(1, r, c, n, ev);
            end
            if (i < total) begin
                left_px  = pxl(0, i / xw, i % xw);
                right_px = pxl(1, i / xw, i % xw);
            end
        end
    endtask

    initial begin
        run_cfg(3, 9, 6);     // main case, ring of four memories
        run_cfg(2, 12, 5);    // shorter window, wider rows
        run_cfg(0, 5, 4);     // R1 zero line count acts as one
        run_cfg(9, 7, 7);     // R1 line count above maximum clamps; R3 R4 full ring
        run_cfg(1, 200, 3);   // R2 width above memory depth clamps
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule